// File: doc/BRIEF.md
# Register Write-Protection Controller

This block sits on a simple CPU-style write bus and guards a small set of control registers against stray writes. It holds a three-bit protect register and decodes the address of every bus write. For each of three guarded groups it raises a gated write-enable only when the matching protect bit is set. The groups are a pair of mode registers, a pair of clock-control registers and a single port-direction register. The guarded registers live elsewhere and load their data from the bus only on these gated strobes.

The mode and clock enables are sticky: once software sets them, they stay set until software writes the protect register again. The port-direction enable is a one-shot. The next bus write to any address other than the protect register itself uses that enable and clears it at the same clock edge. A write to the protect register always loads the value written, and that value takes precedence over the automatic clear. The protect register can be read back at any time. Its unused upper bits read as zero.

Top module: `wprot_top`

## Requirements
- R1: After reset (active-low, asynchronous) the protect register reads 0x00 and no gated write-enable is asserted.
- R2: A bus write to address 0x000A loads data bits 2..0 into protect bits 2..0 at the clock edge. Bits 7..3 of the read-back are always 0.
- R3: `modeWe` is high in exactly the cycle where `busWe` is high, the address is 0x0004 or 0x0005, and protect bit 1 is 1.
- R4: `clkWe` is high in exactly the cycle where `busWe` is high, the address is 0x0006 or 0x0007, and protect bit 0 is 1.
- R5: `dirWe` is high in exactly the cycle where `busWe` is high, the address is 0x03EA, and protect bit 2 is 1.
- R6: A bus write to any address other than 0x000A clears protect bit 2 at that write's clock edge. If that write targets 0x03EA while bit 2 is set, `dirWe` is still asserted for it.
- R7: Protect bits 1 and 0 keep their value across bus writes to every address other than 0x000A.
- R8: A write to 0x000A made while bit 2 is already set leaves bit 2 equal to the written data bit 2. The auto-clear does not override it.
- R9: Cycles without `busWe` change no protect bit and assert no strobe. A write to an address outside the guarded set asserts no strobe. At most one strobe is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busWe | input | 1 | Write strobe, one cycle per write |
| busAddr | input | 16 | Write address |
| busWdata | input | 8 | Write data |
| protRdata | output | 8 | Protect register read-back |
| modeWe | output | 1 | Gated write-enable for the mode register pair |
| clkWe | output | 1 | Gated write-enable for the clock-control pair |
| dirWe | output | 1 | Gated write-enable for the port-direction register |

## Verification
The bench aims at the one-shot bit's edge cases. The first is the write that sets bit 2 and must not clear it. A design that got this wrong would never let a direction write through. The second is a direction write that consumes the enable. A design that cleared the bit one cycle early would drop that write. The third is a protect-register write that lands while bit 2 is set. Here a design with the wrong priority would lose the newly written 1. The bench also checks that idle cycles and unrelated addresses leave the sticky bits alone and fire no strobe. A decoder off by one address would otherwise leak enables.

// File: rtl/wprot_pkg.sv
package wprot_pkg;
  // Decoded addresses; bit positions in the protect register matter to software.
  localparam logic [15:0] PROT_ADDR   = 16'h000A;
  localparam logic [15:0] MODE_ADDR_A = 16'h0004;
  localparam logic [15:0] MODE_ADDR_B = 16'h0005;
  localparam logic [15:0] CLK_ADDR_A  = 16'h0006;
  localparam logic [15:0] CLK_ADDR_B  = 16'h0007;
  localparam logic [15:0] DIR_ADDR    = 16'h03EA;

  localparam int CLK_BIT  = 0;
  localparam int MODE_BIT = 1;
  localparam int DIR_BIT  = 2;
  localparam int PROT_W   = 3;

  // Control-to-datapath strobes.
  typedef struct packed {
    logic loadProt;     // write to protect register this cycle
    logic dropOneShot;  // write elsewhere: consume the one-shot bit
    logic passMode;
    logic passClk;
    logic passDir;
  } protStrobe_t;
endpackage

// File: rtl/wprot_ctrl.sv
module wprot_ctrl
  import wprot_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic              busWe,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [PROT_W-1:0] protBits,
  output protStrobe_t       strb
);
  localparam int N_GROUP = 3;

  logic hitProt;
  logic [N_GROUP-1:0] hitGroup;
  logic [N_GROUP-1:0] passGroup;

  assign hitProt = (busAddr == ADDR_W'(PROT_ADDR));

  // Group index equals its protect-bit position.
  assign hitGroup[CLK_BIT]  = (busAddr == ADDR_W'(CLK_ADDR_A)) ||
                              (busAddr == ADDR_W'(CLK_ADDR_B));
  assign hitGroup[MODE_BIT] = (busAddr == ADDR_W'(MODE_ADDR_A)) ||
                              (busAddr == ADDR_W'(MODE_ADDR_B));
  assign hitGroup[DIR_BIT]  = (busAddr == ADDR_W'(DIR_ADDR));

  for (genvar g = 0; g < N_GROUP; g++) begin : gGate
    assign passGroup[g] = busWe && hitGroup[g] && protBits[g];
  end

  always_comb begin
    strb             = '0;
    strb.loadProt    = busWe && hitProt;
    strb.dropOneShot = busWe && !hitProt;
    strb.passMode    = passGroup[MODE_BIT];
    strb.passClk     = passGroup[CLK_BIT];
    strb.passDir     = passGroup[DIR_BIT];
  end
endmodule

// File: rtl/wprot_dpath.sv
module wprot_dpath
  import wprot_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  protStrobe_t       strb,
  input  logic [DATA_W-1:0] busWdata,
  output logic [PROT_W-1:0] protBits,
  output logic [DATA_W-1:0] protRdata
);
  logic [PROT_W-1:0] protQ;
  logic [PROT_W-1:0] protD;
  wire unusedWdataHi = ^busWdata[DATA_W-1:PROT_W];

  always_comb begin
    protD = protQ;
    if (strb.loadProt) begin
      protD = busWdata[PROT_W-1:0];          // new value beats auto-clear
    end else if (strb.dropOneShot) begin
      protD[DIR_BIT] = 1'b0;                 // sticky bits untouched
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) protQ <= '0;
    else       protQ <= protD;
  end

  assign protBits  = protQ;
  assign protRdata = {{(DATA_W-PROT_W){1'b0}}, protQ};
endmodule

// File: rtl/wprot_top.sv
module wprot_top
  import wprot_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWe,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] protRdata,
  output logic              modeWe,
  output logic              clkWe,
  output logic              dirWe
);
  protStrobe_t       strb;
  logic [PROT_W-1:0] protBits;

  wprot_ctrl #(.ADDR_W(ADDR_W)) ctrl_i (
    .busWe   (busWe),
    .busAddr (busAddr),
    .protBits(protBits),
    .strb    (strb)
  );

  wprot_dpath #(.DATA_W(DATA_W)) dpath_i (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .busWdata (busWdata),
    .protBits (protBits),
    .protRdata(protRdata)
  );

  assign modeWe = strb.passMode;
  assign clkWe  = strb.passClk;
  assign dirWe  = strb.passDir;
endmodule

// File: rtl/wprot_chk.sv
module wprot_chk #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              busWe,
  input logic [ADDR_W-1:0] busAddr,
  input logic [DATA_W-1:0] busWdata,
  input logic [DATA_W-1:0] protRdata,
  input logic              modeWe,
  input logic              clkWe,
  input logic              dirWe
);
  logic hitProt;
  assign hitProt = (busAddr == ADDR_W'(16'h000A));

  AST_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    protRdata[DATA_W-1:3] == '0);                                         // R2
  AST_LOAD_VALUE: assert property (@(posedge clk) disable iff (!rstN)
    busWe && hitProt |=> protRdata[2:0] == $past(busWdata[2:0]));         // R8
  AST_MODE_NEEDS_BIT: assert property (@(posedge clk) disable iff (!rstN)
    modeWe |-> protRdata[1] && busWe);                                    // R3
  AST_CLK_NEEDS_BIT: assert property (@(posedge clk) disable iff (!rstN)
    clkWe |-> protRdata[0] && busWe);                                     // R4
  AST_DIR_NEEDS_BIT: assert property (@(posedge clk) disable iff (!rstN)
    dirWe |-> protRdata[2] && busWe);                                     // R5
  AST_ONESHOT_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    busWe && !hitProt |=> !protRdata[2]);                                 // R6
  AST_STICKY_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    busWe && !hitProt |=> protRdata[1:0] == $past(protRdata[1:0]));       // R7
  AST_IDLE_STABLE: assert property (@(posedge clk) disable iff (!rstN)
    !busWe |=> $stable(protRdata));                                       // R9
  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({modeWe, clkWe, dirWe}));                                    // R9
endmodule

bind wprot_top wprot_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) chk_i (
  .clk(clk), .rstN(rstN), .busWe(busWe), .busAddr(busAddr),
  .busWdata(busWdata), .protRdata(protRdata), .modeWe(modeWe),
  .clkWe(clkWe), .dirWe(dirWe)
);

// File: tb/wprot_top_tb_top.sv
module wprot_top_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busWe = 1'b0;
  logic [15:0] busAddr = '0;
  logic [7:0]  busWdata = '0;
  logic [7:0]  protRdata;
  logic        modeWe, clkWe, dirWe;

  int checks = 0;
  int errors = 0;
  logic [2:0] expProt = 3'b000;
  bit finished = 0;

  always #2 clk = ~clk;  // 250 MHz

  wprot_top dut_i (
    .clk(clk), .rstN(rstN), .busWe(busWe), .busAddr(busAddr),
    .busWdata(busWdata), .protRdata(protRdata), .modeWe(modeWe),
    .clkWe(clkWe), .dirWe(dirWe)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Expected {mode, clk, dir} strobes from the requirements.
  function automatic logic [2:0] expStrobes(input logic we, input logic [15:0] a,
                                            input logic [2:0] p);
    logic m, c, d;
    m = we && (a == 16'h0004 || a == 16'h0005) && p[1];  // R3
    c = we && (a == 16'h0006 || a == 16'h0007) && p[0];  // R4
    d = we && (a == 16'h03EA) && p[2];                   // R5
    return {m, c, d};
  endfunction

  function automatic logic [2:0] nextProt(input logic we, input logic [15:0] a,
                                          input logic [7:0] d, input logic [2:0] p);
    if (!we) return p;                                   // R9
    if (a == 16'h000A) return d[2:0];                    // R2, R8
    return {1'b0, p[1:0]};                               // R6, R7
  endfunction

  task automatic cycle(input logic we, input logic [15:0] a, input logic [7:0] d,
                       input string tag);
    @(negedge clk);
    busWe = we; busAddr = a; busWdata = d;
    #1;
    check({tag, " strobes"}, {5'b0, modeWe, clkWe, dirWe},
          {5'b0, expStrobes(we, a, expProt)});
    check({tag, " readback"}, protRdata, {5'b0, expProt});
    @(posedge clk);
    expProt = nextProt(we, a, d, expProt);
  endtask

  function automatic logic [15:0] pickAddr(input int unsigned r);
    case (r % 8)
      0: return 16'h0004;
      1: return 16'h0005;
      2: return 16'h0006;
      3: return 16'h0007;
      4: return 16'h000A;
      5: return 16'h03EA;
      6: return 16'h000A;
      default: return 16'($urandom);
    endcase
  endfunction

  initial begin
    int unsigned seed;
    seed = $urandom(32'h5EED_1234);
    #9;
    check("R1 reset readback", protRdata, 8'h00);
    check("R1 reset strobes", {5'b0, modeWe, clkWe, dirWe}, 8'h00);
    @(negedge clk); rstN = 1'b1;

    // R5/R6: setting write keeps bit 2; next direction write passes and clears it.
    cycle(1, 16'h000A, 8'hFC, "R2 set dir only");
    cycle(0, 16'h03EA, 8'h00, "R9 idle keeps one-shot");
    cycle(1, 16'h03EA, 8'h55, "R6 dir write consumes");
    cycle(1, 16'h03EA, 8'h55, "R5 dir blocked after clear");
    // R8: protect write while bit 2 set.
    cycle(1, 16'h000A, 8'h07, "R2 set all");
    cycle(1, 16'h000A, 8'h04, "R8 rewrite keeps bit2");
    cycle(1, 16'h000A, 8'h03, "R8 rewrite clears bit2");
    // R7: sticky bits survive other writes.
    cycle(1, 16'h1234, 8'hFF, "R9 unrelated addr");
    cycle(1, 16'h0004, 8'h11, "R3 mode pass");
    cycle(1, 16'h0007, 8'h22, "R4 clk pass");
    cycle(1, 16'h0008, 8'h22, "R9 near miss");
    cycle(1, 16'h0003, 8'h22, "R9 near miss low");
    cycle(0, 16'h0005, 8'h22, "R9 no strobe idle");
    cycle(1, 16'h000A, 8'h00, "R7 clear sticky");
    cycle(1, 16'h0005, 8'h33, "R3 mode blocked");
    cycle(1, 16'h0006, 8'h33, "R4 clk blocked");

    for (int i = 0; i < 4000; i++) begin
      logic we;
      we = ($urandom % 4) != 0;
      cycle(we, pickAddr($urandom), 8'($urandom), "R7 random");
    end

    @(negedge clk);
    busWe = 0;
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(4 * 200000);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule